// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a four-bank double-data-rate SDRAM interface. On each rising clock edge it samples the chip-select, row-strobe, column-strobe and write-enable levels and turns them into a compact command code. It also pulls the bank, row and column fields out of the address pins and keeps, for every bank, an idle/active flag and the row held open in it.

Read and write commands may ask for auto-precharge through address bit 8. The same bit on a precharge command selects all banks. The tracker flags accesses that break the bank protocol, and it stops advancing while clock enable is held low. Every decoded field is registered, so it appears one cycle after the edge that sampled it.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: When `cs_n` is sampled high on a live edge, `cmd_o` shows NOP (code 0) one cycle later, whatever the other strobes are. The command codes are NOP=0, ACT=1, PRE=2, RD=3, WR=4, MRS=5, REF=6.
- R2: With `cs_n`, `ras_n` low and `cas_n` high, `we_n` high gives ACT and `we_n` low gives PRE.
- R3: With `cs_n`, `cas_n` low and `ras_n` high, `we_n` high gives RD and `we_n` low gives WR. With all four strobes low the result is MRS. With `cs_n`, `ras_n`, `cas_n` low and `we_n` high the result is REF. Any other pattern gives NOP.
- R4: On ACT, `row_o` takes `addr[11:0]` and `bank_o` takes `ba`.
- R5: On RD or WR, `col_o` is `{addr[9], addr[7:0]}`, `auto_pre_o` equals `addr[8]` and `bank_o` takes `ba`. On every other command `auto_pre_o` is 0.
- R6: A legal ACT sets `bank_active_o[ba]` and stores the row in `open_row_o[ba*12 +: 12]`. Other banks are untouched.
- R7: PRE with `addr[8]` low closes only bank `ba`. PRE with `addr[8]` high closes every bank and sets `all_banks_o`; `all_banks_o` is 0 for any other command.
- R8: A RD or WR with `addr[8]` high to an active bank leaves that bank idle in the same cycle that the command appears on `cmd_o`.
- R9: A RD or WR to an idle bank, or an ACT to an active bank, raises `err_o` for one cycle and leaves every bank flag and open row unchanged.
- R10: After an edge that samples `cke` low, each following edge is frozen: `cmd_o` shows NOP, `err_o` is 0, and bank state and address fields hold. This lasts up to and including the edge that samples `cke` high again.
- R11: A synchronous active-low reset leaves all banks idle, `cmd_o` at NOP and `err_o`, `auto_pre_o`, `all_banks_o` and the address fields at 0.
- R12: MRS copies `ba` to `bank_o` (the mode register select) and changes no bank state. REF changes no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable, sampled each edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address pins |
| cmd_o | output | 3 | Registered command code |
| bank_o | output | 2 | Registered bank field |
| row_o | output | 12 | Registered row field |
| col_o | output | 9 | Registered column field |
| auto_pre_o | output | 1 | Auto-precharge requested by this access |
| all_banks_o | output | 1 | Precharge targeted all banks |
| err_o | output | 1 | Protocol violation pulse |
| bank_active_o | output | 4 | Per-bank active flag |
| open_row_o | output | 48 | Open row per bank, bank n in bits n*12+11..n*12 |

## Verification
The assertions assume that strobe and address inputs are stable at each rising edge and that reset is held for at least one edge before the first command. The bench changes inputs only on falling edges and starts with reset asserted, so both conditions hold. The properties on bank flags also assume the only way a bank changes state is through a decoded command on a live edge. The bench therefore drives commands only through one issue task. It checks freezing by holding `cke` low across several edges that carry otherwise legal commands.

// File: rtl/sdram_trk_pkg.sv
// Shared types for the SDRAM command tracker.
// Assumes a 3-bit command code; numeric values are part of the port contract.
package sdram_trk_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_PRE = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4,
        CMD_MRS = 3'd5,
        CMD_REF = 3'd6
    } cmd_t;
endpackage

// File: rtl/sdram_cmd_decode.sv
// Combinational decoder from the four active-low strobes to a command code.
// Assumes the caller samples the result on the rising clock edge.
module sdram_cmd_decode
    import sdram_trk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_t cmd
);
    // Map the strobe pattern to a command; chip select high masks everything.
    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b010:  cmd = CMD_PRE;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b000:  cmd = CMD_MRS;
                3'b001:  cmd = CMD_REF;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sdram_bank_slot.sv
// State of one bank: active flag and open row.
// Assumes 'adv' is low on frozen edges and 'sel' marks this bank as target.
module sdram_bank_slot
    import sdram_trk_pkg::*;
#(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             sel,
    input  cmd_t             cmd,
    input  logic             flag8,
    input  logic [ROW_W-1:0] row_in,
    output logic             active_o,
    output logic [ROW_W-1:0] row_o
);
    // Apply legal commands to this bank; illegal ones leave it untouched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            row_o    <= '0;
        end else if (adv) begin
            case (cmd)
                CMD_ACT: if (sel && !active_o) begin
                    active_o <= 1'b1;
                    row_o    <= row_in;
                end
                CMD_PRE: if (sel || flag8) active_o <= 1'b0;
                CMD_RD, CMD_WR: if (sel && active_o && flag8) active_o <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sdram_cmd_tracker.sv
// Top: samples SDRAM control pins, registers decoded fields, tracks banks.
// Assumes inputs are stable around each rising edge; reset is synchronous.
module sdram_cmd_tracker
    import sdram_trk_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int ROW_W = 12,
    parameter int COL_LO_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [$clog2(BANKS)-1:0] ba,
    input  logic [ROW_W-1:0]       addr,
    output logic [2:0]             cmd_o,
    output logic [$clog2(BANKS)-1:0] bank_o,
    output logic [ROW_W-1:0]       row_o,
    output logic [COL_LO_W:0]      col_o,
    output logic                   auto_pre_o,
    output logic                   all_banks_o,
    output logic                   err_o,
    output logic [BANKS-1:0]       bank_active_o,
    output logic [BANKS*ROW_W-1:0] open_row_o
);
    localparam int BA_W   = $clog2(BANKS);
    localparam int AP_BIT = COL_LO_W;
    localparam int HI_BIT = COL_LO_W + 1;

    cmd_t       dec_cmd;
    logic       cke_q;
    logic       adv;
    logic       tgt_active;
    logic       is_access;
    logic       bad_cmd;

    sdram_cmd_decode u_dec (
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .cmd  (dec_cmd)
    );

    // Remember the previous clock-enable sample; low suspends the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_q <= 1'b1;
        else        cke_q <= cke;
    end

    assign adv        = cke_q;
    assign tgt_active = bank_active_o[ba];
    assign is_access  = (dec_cmd == CMD_RD) || (dec_cmd == CMD_WR);
    assign bad_cmd    = ((dec_cmd == CMD_ACT) && tgt_active) || (is_access && !tgt_active);

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            sdram_bank_slot #(.ROW_W(ROW_W)) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .adv     (adv),
                .sel     (ba == BA_W'(b)),
                .cmd     (dec_cmd),
                .flag8   (addr[AP_BIT]),
                .row_in  (addr),
                .active_o(bank_active_o[b]),
                .row_o   (open_row_o[b*ROW_W +: ROW_W])
            );
        end
    endgenerate

    // Register the decoded command and its address fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o       <= CMD_NOP;
            bank_o      <= '0;
            row_o       <= '0;
            col_o       <= '0;
            auto_pre_o  <= 1'b0;
            all_banks_o <= 1'b0;
            err_o       <= 1'b0;
        end else if (!adv) begin
            cmd_o       <= CMD_NOP;
            auto_pre_o  <= 1'b0;
            all_banks_o <= 1'b0;
            err_o       <= 1'b0;
        end else begin
            cmd_o       <= dec_cmd;
            err_o       <= bad_cmd;
            auto_pre_o  <= is_access && addr[AP_BIT];
            all_banks_o <= (dec_cmd == CMD_PRE) && addr[AP_BIT];
            if (dec_cmd inside {CMD_ACT, CMD_PRE, CMD_RD, CMD_WR, CMD_MRS})
                bank_o <= ba;
            if (dec_cmd == CMD_ACT)
                row_o <= addr;
            if (is_access)
                col_o <= {addr[HI_BIT], addr[COL_LO_W-1:0]};
        end
    end

    // Assertions guarding the registered outputs and bank state.
    p_cs_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_q && cs_n) |=> (cmd_o == CMD_NOP));

    p_col_build_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_q && !cs_n && ras_n && !cas_n) |=>
        (col_o == {$past(addr[HI_BIT]), $past(addr[COL_LO_W-1:0])}));

    p_act_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ACT && !err_o) |-> bank_active_o[bank_o]);

    p_pre_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_PRE && all_banks_o) |-> (bank_active_o == '0));

    p_ap_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o == CMD_RD || cmd_o == CMD_WR) && auto_pre_o && !err_o) |-> !bank_active_o[bank_o]);

    p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_q && bad_cmd) |=> (err_o && $stable(bank_active_o) && $stable(open_row_o)));

    p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_q |=> (cmd_o == CMD_NOP && !err_o && $stable(bank_active_o) && $stable(row_o)));
endmodule

// File: tb/sdram_cmd_tracker_bench.sv
// Directed bench for the SDRAM command tracker.
module sdram_cmd_tracker_bench;
    localparam int C_NOP = 0, C_ACT = 1, C_PRE = 2, C_RD = 3, C_WR = 4, C_MRS = 5, C_REF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;
    logic [2:0]  cmd_o;
    logic [1:0]  bank_o;
    logic [11:0] row_o;
    logic [8:0]  col_o;
    logic        auto_pre_o, all_banks_o, err_o;
    logic [3:0]  bank_active_o;
    logic [47:0] open_row_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sdram_cmd_tracker u_sdram_cmd_tracker (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o),
        .bank_o(bank_o), .row_o(row_o), .col_o(col_o), .auto_pre_o(auto_pre_o),
        .all_banks_o(all_banks_o), .err_o(err_o), .bank_active_o(bank_active_o),
        .open_row_o(open_row_o)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Drive one strobe pattern {cs,ras,cas,we} at a falling edge; return after the next falling edge.
    task automatic issue(input logic [3:0] pins, input logic [1:0] b, input logic [11:0] a);
        {cs_n, ras_n, cas_n, we_n} = pins;
        ba = b;
        addr = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic op(input int c, input logic [1:0] b, input logic [11:0] a);
        logic [3:0] p;
        case (c)
            C_ACT: p = 4'b0011;
            C_PRE: p = 4'b0010;
            C_RD:  p = 4'b0101;
            C_WR:  p = 4'b0100;
            C_MRS: p = 4'b0000;
            C_REF: p = 4'b0001;
            default: p = 4'b0111;
        endcase
        issue(p, b, a);
    endtask

    function automatic int row_of(input int b);
        return int'(open_row_o[b*12 +: 12]);
    endfunction

    task automatic t_reset;
        rst_n = 1'b0;
        op(C_NOP, 0, 0);
        op(C_NOP, 0, 0);
        rst_n = 1'b1;
        chk("R11", "cmd", cmd_o, C_NOP);
        chk("R11", "active", bank_active_o, 0);
        chk("R11", "err", err_o, 0);
        chk("R11", "row", row_o, 0);
    endtask

    task automatic t_decode;
        issue(4'b1011, 1, 12'hFFF);
        chk("R1", "cs masked act", cmd_o, C_NOP);
        chk("R1", "no bank opened", bank_active_o, 0);
        issue(4'b1000, 2, 0);
        chk("R1", "cs masked mrs", cmd_o, C_NOP);
        op(C_MRS, 2, 12'h033);
        chk("R3", "mrs code", cmd_o, C_MRS);
        chk("R12", "mrs bank", bank_o, 2);
        chk("R12", "mrs no state", bank_active_o, 0);
        op(C_REF, 1, 0);
        chk("R3", "ref code", cmd_o, C_REF);
        chk("R12", "ref no state", bank_active_o, 0);
        issue(4'b0110, 0, 0);
        chk("R3", "burst-stop pattern is nop", cmd_o, C_NOP);
    endtask

    task automatic t_access;
        op(C_ACT, 1, 12'hA5C);
        chk("R2", "act code", cmd_o, C_ACT);
        chk("R4", "row", row_o, 12'hA5C);
        chk("R4", "bank", bank_o, 1);
        chk("R6", "active", bank_active_o, 4'b0010);
        chk("R6", "open row", row_of(1), 12'hA5C);
        op(C_ACT, 3, 12'h123);
        chk("R6", "two active", bank_active_o, 4'b1010);
        chk("R6", "bank1 row kept", row_of(1), 12'hA5C);
        op(C_RD, 1, 12'h2AB);
        chk("R3", "rd code", cmd_o, C_RD);
        chk("R5", "rd col", col_o, 9'h1AB);
        chk("R5", "no ap", auto_pre_o, 0);
        chk("R5", "still active", bank_active_o, 4'b1010);
        op(C_WR, 3, 12'h055);
        chk("R3", "wr code", cmd_o, C_WR);
        chk("R5", "wr col", col_o, 9'h055);
        chk("R5", "wr bank", bank_o, 3);
        chk("R9", "legal no err", err_o, 0);
    endtask

    task automatic t_precharge;
        op(C_PRE, 3, 12'h000);
        chk("R2", "pre code", cmd_o, C_PRE);
        chk("R7", "single close", bank_active_o, 4'b0010);
        chk("R7", "all flag low", all_banks_o, 0);
        op(C_ACT, 0, 12'h0F0);
        op(C_ACT, 2, 12'h00F);
        chk("R6", "three active", bank_active_o, 4'b0111);
        op(C_PRE, 0, 12'h100);
        chk("R7", "all closed", bank_active_o, 0);
        chk("R7", "all flag", all_banks_o, 1);
        op(C_NOP, 0, 0);
        chk("R7", "all flag drops", all_banks_o, 0);
    endtask

    task automatic t_autopre;
        op(C_ACT, 2, 12'h777);
        op(C_RD, 2, 12'h3FF);
        chk("R5", "ap flag", auto_pre_o, 1);
        chk("R5", "ap col", col_o, 9'h1FF);
        chk("R8", "rd ap closes", bank_active_o, 0);
        op(C_ACT, 0, 12'h111);
        op(C_WR, 0, 12'h104);
        chk("R8", "wr ap closes", bank_active_o, 0);
        chk("R8", "no err", err_o, 0);
    endtask

    task automatic t_errors;
        op(C_RD, 1, 12'h004);
        chk("R9", "rd idle err", err_o, 1);
        chk("R9", "state same", bank_active_o, 0);
        op(C_NOP, 0, 0);
        chk("R9", "err pulse ends", err_o, 0);
        op(C_ACT, 1, 12'h222);
        op(C_ACT, 1, 12'h333);
        chk("R9", "act active err", err_o, 1);
        chk("R9", "row kept", row_of(1), 12'h222);
        chk("R9", "flag kept", bank_active_o, 4'b0010);
        op(C_WR, 3, 12'h100);
        chk("R9", "wr idle err", err_o, 1);
        chk("R9", "wr idle no change", bank_active_o, 4'b0010);
    endtask

    task automatic t_freeze;
        cke = 1'b0;
        op(C_ACT, 0, 12'h444);
        chk("R10", "edge sampling low still live", bank_active_o, 4'b0011);
        op(C_PRE, 1, 12'h100);
        chk("R10", "frozen cmd", cmd_o, C_NOP);
        chk("R10", "frozen state", bank_active_o, 4'b0011);
        chk("R10", "frozen row field", row_o, 12'h444);
        cke = 1'b1;
        op(C_ACT, 2, 12'h555);
        chk("R10", "edge sampling high still frozen", bank_active_o, 4'b0011);
        op(C_ACT, 2, 12'h556);
        chk("R10", "resumed", bank_active_o, 4'b0111);
        chk("R10", "resumed row", row_of(2), 12'h556);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_decode();
        t_access();
        t_precharge();
        t_autopre();
        t_errors();
        t_freeze();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule